// File: doc/BRIEF.md
# Multiplicative Boost Frequency Governor

This block decides the memory clock frequency that an activity monitor asks for. Each monitor channel delivers an event that carries its current average count and may also carry an "activity high" flag, an "activity low" flag, or both. The governor keeps a boost value for each channel. The boost grows geometrically with an additive step when activity is high, and decays geometrically when activity is low. The governor turns the average count into a load frequency, adds the boost, applies a floor, and reports the largest target over all channels. For each event it also returns fresh watermark values and fresh event-enable bits, which software or the monitor writes back.

All divisions run on one shared sequential divider, so an update takes a few hundred cycles. Events enter on a valid/ready input. The input is back-pressured (ev_ready low) from the moment an event is accepted until its result has been taken. The result leaves on a valid/ready output. While res_valid is high and res_ready is low, every result field stays stable. The block applies no frequency change itself.

Top module: `boost_governor`

## Requirements
- R1: After reset, ev_ready is 1, res_valid is 0 and res_tgt is FLOOR_KHZ (102000). Every channel starts with boost 0, both enables at 1 and a target of FLOOR_KHZ.
- R2: An event with ev_up=1 sets boost = 16000 + floor(boost*up_coef/100) and sets both enables (res_en_above and res_en_below) to 1.
- R3: If that upper result is at least max_khz, boost becomes max_khz and res_en_above becomes 0.
- R4: An event with ev_dn=1 and ev_up=0 sets boost = floor(boost*dn_coef/100) and sets both enables to 1. If the result is below 8000, boost becomes 0 and res_en_below becomes 0.
- R5: An event with neither flag leaves the channel's boost and enables unchanged, apart from R7.
- R6: An event with both flags set is handled as an upper event only.
- R7: If the channel's dependency threshold is nonzero, res_en_below is forced to 1 when ev_avg >= threshold. Otherwise it is forced to 0 when the new boost is 0.
- R8: res_ch_tgt = max(102000, floor(floor(avg/period) * floor(10000/up_thr) / 100) + boost).
- R9: res_wm_up = floor(cur_khz*period*up_thr/100). res_wm_lo uses dn_thr in the same way.
- R10: With band = band_khz*period, res_avg_up = avg + band and res_avg_lo = avg - band, or 0 when band exceeds avg.
- R11: Channels keep separate state. res_tgt is the maximum of all channels' latest targets.
- R12: An event is taken when ev_valid and ev_ready are both 1. ev_ready stays 0 until the result is taken (res_valid and res_ready both 1). The result fields stay stable while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Governor idle, event may be taken |
| ev_chan | input | CHW | Channel index of the event |
| ev_up | input | 1 | Activity-high flag |
| ev_dn | input | 1 | Activity-low flag |
| ev_avg | input | FW | Channel average count |
| cur_khz | input | FW | Present clock frequency in kHz |
| max_khz | input | FW | Highest allowed frequency in kHz |
| band_khz | input | FW | Average hysteresis band per period unit |
| period | input | PW | Sampling period, nonzero |
| cfg_up_coef | input | NCH*CW | Per-channel growth coefficient in percent |
| cfg_dn_coef | input | NCH*CW | Per-channel decay coefficient in percent |
| cfg_up_thr | input | NCH*TW | Per-channel upper threshold in percent, nonzero |
| cfg_dn_thr | input | NCH*TW | Per-channel lower threshold in percent |
| cfg_dep_thr | input | NCH*FW | Per-channel average-dependency threshold, 0 disables it |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_chan | output | CHW | Channel of the result |
| res_tgt | output | FW | Maximum target over all channels |
| res_ch_tgt | output | FW | Target of this channel |
| res_boost | output | FW | New boost of this channel |
| res_wm_up | output | FW | New raw upper watermark |
| res_wm_lo | output | FW | New raw lower watermark |
| res_avg_up | output | FW | New average upper watermark |
| res_avg_lo | output | FW | New average lower watermark |
| res_en_above | output | 1 | New consecutive-above enable |
| res_en_below | output | 1 | New consecutive-below enable |

## Verification
The bench sweeps every flag combination (none, up, down, both) on both channels. The average values range from zero to well above the dependency threshold, so the priority of upper events and both branches of the dependency rule are separated. A run of repeated upper events under a lowered maximum drives the boost into its clamp. A long run of lower events then decays it until it snaps to zero, which shows the enable-clear rules apart from the plain arithmetic. Changes of the present frequency and the period check the watermark and load formulas apart from the boost path, and each result is held against back-pressure before it is taken.

// File: rtl/gov_pkg.sv
package gov_pkg;
  typedef enum logic [3:0] {
    G_IDLE, G_BST, G_LD, G_CF, G_LS, G_WU, G_WL, G_CM, G_MX, G_OUT
  } gov_st_e;
endpackage

// File: rtl/gov_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
module gov_div #(
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] quot
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   rem_q, quo_q, den_q;
  logic [CNTW-1:0] cnt_q;
  logic [DW:0]     sh, diff;

  assign sh   = {rem_q, quo_q[DW-1]};
  assign diff = sh - {1'b0, den_q};
  assign quot = quo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; quo_q <= '0; den_q <= '0; cnt_q <= '0;
      busy  <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0; quo_q <= num; den_q <= den;
        cnt_q <= CNTW'(DW); busy <= 1'b1;
      end else if (busy) begin
        if (!diff[DW]) begin
          rem_q <= diff[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= sh[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNTW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  AST_DIV_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R8
endmodule

// File: rtl/gov_max.sv
// Maximum over N packed words, linear compare chain.
module gov_max #(
  parameter int N = 2,
  parameter int W = 32
) (
  input  logic [N*W-1:0] vec,
  output logic [W-1:0]   mx
);
  logic [W-1:0] run [N];
  assign run[0] = vec[W-1:0];
  for (genvar g = 1; g < N; g++) begin : g_chain
    assign run[g] = (vec[g*W +: W] > run[g-1]) ? vec[g*W +: W] : run[g-1];
  end
  assign mx = run[N-1];
endmodule

// File: rtl/boost_governor.sv
module boost_governor #(
  parameter int NCH       = 2,
  parameter int FW        = 32,
  parameter int CW        = 10,
  parameter int TW        = 7,
  parameter int PW        = 8,
  parameter int STEP_KHZ  = 16000,
  parameter int FLOOR_KHZ = 102000,
  parameter int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [CHW-1:0]    ev_chan,
  input  logic              ev_up,
  input  logic              ev_dn,
  input  logic [FW-1:0]     ev_avg,
  input  logic [FW-1:0]     cur_khz,
  input  logic [FW-1:0]     max_khz,
  input  logic [FW-1:0]     band_khz,
  input  logic [PW-1:0]     period,
  input  logic [NCH*CW-1:0] cfg_up_coef,
  input  logic [NCH*CW-1:0] cfg_dn_coef,
  input  logic [NCH*TW-1:0] cfg_up_thr,
  input  logic [NCH*TW-1:0] cfg_dn_thr,
  input  logic [NCH*FW-1:0] cfg_dep_thr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [CHW-1:0]    res_chan,
  output logic [FW-1:0]     res_tgt,
  output logic [FW-1:0]     res_ch_tgt,
  output logic [FW-1:0]     res_boost,
  output logic [FW-1:0]     res_wm_up,
  output logic [FW-1:0]     res_wm_lo,
  output logic [FW-1:0]     res_avg_up,
  output logic [FW-1:0]     res_avg_lo,
  output logic              res_en_above,
  output logic              res_en_below
);
  import gov_pkg::*;
  localparam int DW = FW + 16;

  gov_st_e st;
  logic [CHW-1:0] c_ch;
  logic           c_up, c_dn;
  logic [FW-1:0]  c_avg;
  logic [FW-1:0]  boost_q [NCH];
  logic           ea_q [NCH];
  logic           eb_q [NCH];
  logic [NCH*FW-1:0] tgt_flat;
  logic [FW-1:0]  w_boost, w_tgt, w_wu, w_wl, max_out;
  logic           w_ea, w_eb;
  logic [DW-1:0]  q_load, q_coef;

  // divider control
  logic          is_div, div_run, div_start, div_busy, div_done;
  logic [DW-1:0] div_a, div_b, div_q;
  assign is_div    = st inside {G_BST, G_LD, G_CF, G_LS, G_WU, G_WL};
  assign div_start = is_div && !div_run;

  // per-channel config of the captured channel
  logic [CW-1:0] up_c, dn_c;
  logic [TW-1:0] up_t, dn_t;
  logic [FW-1:0] dep_t;
  assign up_c  = cfg_up_coef[c_ch*CW +: CW];
  assign dn_c  = cfg_dn_coef[c_ch*CW +: CW];
  assign up_t  = cfg_up_thr[c_ch*TW +: TW];
  assign dn_t  = cfg_dn_thr[c_ch*TW +: TW];
  assign dep_t = cfg_dep_thr[c_ch*FW +: FW];

  always_comb begin
    div_b = DW'(100);
    div_a = '0;
    unique case (st)
      G_BST: div_a = DW'(boost_q[c_ch]) * DW'(c_up ? up_c : dn_c);
      G_LD:  begin div_a = DW'(c_avg); div_b = DW'(period); end
      G_CF:  begin div_a = DW'(10000); div_b = DW'(up_t); end
      G_LS:  div_a = q_load * q_coef;
      G_WU:  div_a = DW'(cur_khz) * DW'(period) * DW'(up_t);
      G_WL:  div_a = DW'(cur_khz) * DW'(period) * DW'(dn_t);
      default: div_a = '0;
    endcase
  end

  gov_div #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_a), .den(div_b),
    .busy(div_busy), .done(div_done), .quot(div_q)
  );

  // boost update and enable rules (R2..R7)
  logic [DW-1:0] bst_sum;
  logic [FW-1:0] nb;
  logic          nea, neb;
  assign bst_sum = DW'(STEP_KHZ) + div_q;
  always_comb begin
    nb  = boost_q[c_ch];
    nea = ea_q[c_ch];
    neb = eb_q[c_ch];
    if (c_up) begin
      neb = 1'b1;
      if (bst_sum >= DW'(max_khz)) begin nb = max_khz; nea = 1'b0; end
      else begin nb = bst_sum[FW-1:0]; nea = 1'b1; end
    end else if (c_dn) begin
      nea = 1'b1;
      if (div_q < DW'(STEP_KHZ / 2)) begin nb = '0; neb = 1'b0; end
      else begin nb = div_q[FW-1:0]; neb = 1'b1; end
    end
    if (dep_t != '0) begin
      if (c_avg >= dep_t) neb = 1'b1;
      else if (nb == '0) neb = 1'b0;
    end
  end

  // target with floor (R8), average band (R10)
  logic [DW-1:0] tgt_sum, band_w;
  logic [FW-1:0] tgt_c;
  assign tgt_sum = div_q + DW'(w_boost);
  assign tgt_c   = (tgt_sum < DW'(FLOOR_KHZ)) ? FW'(FLOOR_KHZ) : tgt_sum[FW-1:0];
  assign band_w  = DW'(band_khz) * DW'(period);

  gov_max #(.N(NCH), .W(FW)) u_max (.vec(tgt_flat), .mx(max_out));

  assign ev_ready  = (st == G_IDLE);
  assign res_valid = (st == G_OUT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_run <= 1'b0;
    else if (div_start) div_run <= 1'b1;
    else if (div_done) div_run <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= G_IDLE;
      c_ch <= '0; c_up <= 1'b0; c_dn <= 1'b0; c_avg <= '0;
      for (int i = 0; i < NCH; i++) begin
        boost_q[i] <= '0; ea_q[i] <= 1'b1; eb_q[i] <= 1'b1;
        tgt_flat[i*FW +: FW] <= FW'(FLOOR_KHZ);
      end
      w_boost <= '0; w_tgt <= '0; w_wu <= '0; w_wl <= '0;
      w_ea <= 1'b1; w_eb <= 1'b1; q_load <= '0; q_coef <= '0;
      res_chan <= '0; res_tgt <= FW'(FLOOR_KHZ); res_ch_tgt <= FW'(FLOOR_KHZ);
      res_boost <= '0; res_wm_up <= '0; res_wm_lo <= '0;
      res_avg_up <= '0; res_avg_lo <= '0;
      res_en_above <= 1'b1; res_en_below <= 1'b1;
    end else begin
      unique case (st)
        G_IDLE: if (ev_valid) begin
          c_ch <= ev_chan; c_up <= ev_up; c_dn <= ev_dn; c_avg <= ev_avg;
          st <= G_BST;
        end
        G_BST: if (div_done) begin
          w_boost <= nb; w_ea <= nea; w_eb <= neb; st <= G_LD;
        end
        G_LD: if (div_done) begin q_load <= div_q; st <= G_CF; end
        G_CF: if (div_done) begin q_coef <= div_q; st <= G_LS; end
        G_LS: if (div_done) begin w_tgt <= tgt_c; st <= G_WU; end
        G_WU: if (div_done) begin w_wu <= div_q[FW-1:0]; st <= G_WL; end
        G_WL: if (div_done) begin w_wl <= div_q[FW-1:0]; st <= G_CM; end
        G_CM: begin
          boost_q[c_ch] <= w_boost;
          ea_q[c_ch]    <= w_ea;
          eb_q[c_ch]    <= w_eb;
          tgt_flat[c_ch*FW +: FW] <= w_tgt;
          res_chan     <= c_ch;
          res_ch_tgt   <= w_tgt;
          res_boost    <= w_boost;
          res_wm_up    <= w_wu;
          res_wm_lo    <= w_wl;
          res_avg_up   <= FW'(DW'(c_avg) + band_w);
          res_avg_lo   <= (DW'(c_avg) > band_w) ? FW'(DW'(c_avg) - band_w) : '0;
          res_en_above <= w_ea;
          res_en_below <= w_eb;
          st <= G_MX;
        end
        G_MX:  begin res_tgt <= max_out; st <= G_OUT; end
        G_OUT: if (res_ready) st <= G_IDLE;
        default: st <= G_IDLE;
      endcase
    end
  end

  AST_TGT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_tgt >= FW'(FLOOR_KHZ)); // R8
  AST_OUT_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_tgt >= res_ch_tgt); // R11
  AST_BOOST_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == G_CM && c_up) |-> w_boost <= max_khz); // R3
  AST_DECAY_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == G_CM && c_dn && !c_up) |-> (w_boost == '0 || w_boost >= FW'(STEP_KHZ / 2))); // R4
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_tgt) && $stable(res_boost))); // R12
endmodule

// File: tb/tb_boost_governor.sv
`timescale 1ns/1ps
module tb_boost_governor;
  localparam int NCH = 2, FW = 32, CW = 10, TW = 7, PW = 8;
  localparam longint STEP = 16000, FLOOR = 102000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic ev_valid = 0, ev_ready, ev_up = 0, ev_dn = 0, res_valid, res_ready = 0;
  logic [0:0] ev_chan = '0, res_chan;
  logic [FW-1:0] ev_avg = '0, cur_khz, max_khz, band_khz;
  logic [PW-1:0] period;
  logic [NCH*CW-1:0] cfg_up_coef, cfg_dn_coef;
  logic [NCH*TW-1:0] cfg_up_thr, cfg_dn_thr;
  logic [NCH*FW-1:0] cfg_dep_thr;
  logic [FW-1:0] res_tgt, res_ch_tgt, res_boost, res_wm_up, res_wm_lo, res_avg_up, res_avg_lo;
  logic res_en_above, res_en_below;

  boost_governor dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_chan(ev_chan),
    .ev_up(ev_up), .ev_dn(ev_dn), .ev_avg(ev_avg), .cur_khz(cur_khz), .max_khz(max_khz),
    .band_khz(band_khz), .period(period), .cfg_up_coef(cfg_up_coef), .cfg_dn_coef(cfg_dn_coef),
    .cfg_up_thr(cfg_up_thr), .cfg_dn_thr(cfg_dn_thr), .cfg_dep_thr(cfg_dep_thr),
    .res_valid(res_valid), .res_ready(res_ready), .res_chan(res_chan), .res_tgt(res_tgt),
    .res_ch_tgt(res_ch_tgt), .res_boost(res_boost), .res_wm_up(res_wm_up), .res_wm_lo(res_wm_lo),
    .res_avg_up(res_avg_up), .res_avg_lo(res_avg_lo), .res_en_above(res_en_above),
    .res_en_below(res_en_below)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  longint upc [2] = '{200, 800};
  longint dnc [2] = '{50, 90};
  longint upt [2] = '{60, 27};
  longint dnt [2] = '{40, 10};
  longint dep [2] = '{0, 50000};
  longint mb [2] = '{0, 0};
  longint mt [2] = '{FLOOR, FLOOR};
  bit mea [2] = '{1, 1};
  bit meb [2] = '{1, 1};

  task automatic chk(string req, string what, longint got, longint exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic run_ev(int ch, bit up, bit dn, longint avg);
    longint b, q, s, load, t, band, al, mx;
    bit ea, eb;
    longint per = longint'(period);
    b = mb[ch]; ea = mea[ch]; eb = meb[ch];
    if (up) begin                      // R2, R3, R6
      q = (b * upc[ch]) / 100; s = STEP + q; eb = 1;
      if (s >= longint'(max_khz)) begin b = longint'(max_khz); ea = 0; end
      else begin b = s; ea = 1; end
    end else if (dn) begin             // R4
      q = (b * dnc[ch]) / 100; ea = 1;
      if (q < STEP / 2) begin b = 0; eb = 0; end else begin b = q; eb = 1; end
    end                                // R5: nothing otherwise
    if (dep[ch] != 0) begin            // R7
      if (avg >= dep[ch]) eb = 1; else if (b == 0) eb = 0;
    end
    load = ((avg / per) * (10000 / upt[ch])) / 100;
    t = load + b; if (t < FLOOR) t = FLOOR;
    band = longint'(band_khz) * per;
    al = (avg > band) ? avg - band : 0;
    mb[ch] = b; mea[ch] = ea; meb[ch] = eb; mt[ch] = t;
    mx = (mt[0] > mt[1]) ? mt[0] : mt[1];

    @(negedge clk);
    while (!ev_ready) @(negedge clk);
    ev_valid = 1; ev_chan = 1'(ch); ev_up = up; ev_dn = dn; ev_avg = FW'(avg);
    @(negedge clk);
    ev_valid = 0;
    chk("R12", "ready low after accept", longint'(ev_ready), 0);
    while (!res_valid) @(negedge clk);
    chk("R11", "channel", longint'(res_chan), ch);
    chk(up ? "R2" : (dn ? "R4" : "R5"), "boost", longint'(res_boost), b);
    chk(up ? "R3" : "R4", "en_above", longint'(res_en_above), ea);
    chk("R7", "en_below", longint'(res_en_below), eb);
    chk("R8", "channel target", longint'(res_ch_tgt), t);
    chk("R11", "overall target", longint'(res_tgt), mx);
    chk("R9", "wm_up", longint'(res_wm_up), (longint'(cur_khz) * per * upt[ch]) / 100);
    chk("R9", "wm_lo", longint'(res_wm_lo), (longint'(cur_khz) * per * dnt[ch]) / 100);
    chk("R10", "avg_up", longint'(res_avg_up), avg + band);
    chk("R10", "avg_lo", longint'(res_avg_lo), al);
    @(negedge clk);
    chk("R12", "valid held", longint'(res_valid), 1);
    chk("R12", "target held", longint'(res_tgt), mx);
    res_ready = 1;
    @(negedge clk);
    res_ready = 0;
    chk("R12", "valid drops after take", longint'(res_valid), 0);
    chk("R12", "ready back", longint'(ev_ready), 1);
  endtask

  initial begin
    cfg_up_coef = {CW'(upc[1]), CW'(upc[0])};
    cfg_dn_coef = {CW'(dnc[1]), CW'(dnc[0])};
    cfg_up_thr  = {TW'(upt[1]), TW'(upt[0])};
    cfg_dn_thr  = {TW'(dnt[1]), TW'(dnt[0])};
    cfg_dep_thr = {FW'(dep[1]), FW'(dep[0])};
    max_khz = 924000; cur_khz = 924000; band_khz = 5544; period = 12;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset ready", longint'(ev_ready), 1);
    chk("R1", "reset valid", longint'(res_valid), 0);
    chk("R1", "reset target", longint'(res_tgt), FLOOR);
    // sweep: flag combinations x channels x average levels (R2 R4 R5 R6 R7)
    for (int rep = 0; rep < 6; rep++)
      for (int k = 0; k < 4; k++)
        for (int ch = 0; ch < 2; ch++)
          run_ev(ch, k[0], k[1], longint'(rep * 37000 + k * 9000 + ch * 5000));
    // saturation and decay (R3 R4)
    max_khz = 150000;
    for (int i = 0; i < 6; i++) run_ev(1, 1, 0, 60000);
    for (int i = 0; i < 32; i++) run_ev(1, 0, 1, 20000);
    for (int i = 0; i < 5; i++) run_ev(0, 1, 0, 400000);
    // other frequency and period (R9 R10 R8)
    cur_khz = 408000; period = 16; band_khz = 900;
    for (int i = 0; i < 8; i++) run_ev(i % 2, i[1], i[2], longint'(i * 123457));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule